// File: doc/BRIEF.md
# FFT Phase Sequencer with Exclusive Memory Ownership

This block sits at the top of a memory-based FFT processor. It drives three worker units through a transform in a fixed order: the sample loader, the butterfly engine and the result streamer. Each worker gets a one-cycle start pulse. The sequencer then waits for that worker's done strobe before it starts the next one. When the streamer finishes, the sequencer raises a one-cycle completion flag and goes back to idle.

All three workers share one memory port, which holds a real part and an imaginary part. Each worker presents its own address, write data and write enable. The sequencer passes through only the request of the worker that currently owns the transform. The requests of the other workers are masked: their write enables never reach the memory. While no worker owns the transform, the memory sees address zero, zero data and no write. Read data from the memory goes to all workers at the same time, whoever owns the port. An active-high synchronous reset returns the sequencer to idle at any point. The workers take the same reset.

Top module: `fft_phase_sequencer`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `busy`, `complete`, `mem_we` and all three start pulses are 0.
- R2: If `go` is high in a cycle where the sequencer is idle (both `busy` and `complete` low), then `ld_start` is high for exactly the next cycle and `busy` is high from that cycle on.
- R3: The phases run in the order load, butterfly, output. A done strobe from the active worker makes the next worker's start pulse high in the following cycle. A done strobe that arrives in the same cycle as that worker's start pulse is accepted.
- R4: A done strobe from a worker that is not active has no effect: no start pulse, no phase change and no completion flag.
- R5: While a phase is active, `mem_addr`, `mem_wr_re`, `mem_wr_im` and `mem_we` equal the active worker's request in the same cycle. The loader is the active worker in the load phase, the butterfly engine in the butterfly phase and the streamer in the output phase.
- R6: A write enable from a worker that is not active never reaches `mem_we`. While no phase is active, `mem_we` is 0 and `mem_addr`, `mem_wr_re` and `mem_wr_im` are 0.
- R7: `rd_re` and `rd_im` always equal `mem_rd_re` and `mem_rd_im` in the same cycle, in every state.
- R8: A done strobe from the streamer makes `complete` high for exactly one cycle, with `busy` low. The sequencer is idle in the cycle after that.
- R9: `go` has no effect while a transform is in progress, and none in the completion cycle.
- R10: Asserting reset in the middle of a transform abandons it. After release the sequencer is idle and accepts a new `go`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Request to begin a transform |
| ld_start | output | 1 | Start pulse to the loader |
| ld_done | input | 1 | Loader finished strobe |
| bf_start | output | 1 | Start pulse to the butterfly engine |
| bf_done | input | 1 | Butterfly engine finished strobe |
| os_start | output | 1 | Start pulse to the output streamer |
| os_done | input | 1 | Output streamer finished strobe |
| ld_addr | input | ADDR_W | Loader memory address |
| ld_wr_re | input | DATA_W | Loader write data, real part |
| ld_wr_im | input | DATA_W | Loader write data, imaginary part |
| ld_we | input | 1 | Loader write enable |
| bf_addr | input | ADDR_W | Butterfly memory address |
| bf_wr_re | input | DATA_W | Butterfly write data, real part |
| bf_wr_im | input | DATA_W | Butterfly write data, imaginary part |
| bf_we | input | 1 | Butterfly write enable |
| os_addr | input | ADDR_W | Streamer memory address |
| os_wr_re | input | DATA_W | Streamer write data, real part |
| os_wr_im | input | DATA_W | Streamer write data, imaginary part |
| os_we | input | 1 | Streamer write enable |
| mem_addr | output | ADDR_W | Shared memory address |
| mem_wr_re | output | DATA_W | Shared memory write data, real part |
| mem_wr_im | output | DATA_W | Shared memory write data, imaginary part |
| mem_we | output | 1 | Shared memory write enable |
| mem_rd_re | input | DATA_W | Shared memory read data, real part |
| mem_rd_im | input | DATA_W | Shared memory read data, imaginary part |
| rd_re | output | DATA_W | Read data to all workers, real part |
| rd_im | output | DATA_W | Read data to all workers, imaginary part |
| busy | output | 1 | A transform phase is active |
| complete | output | 1 | One-cycle transform-finished flag |

## Verification
The hardest case to reach from the ports is a worker that is not active raising its write enable and its done strobe while another worker owns memory. In a normal system such a worker is quiet. The bench therefore holds every phase open and drives all eight combinations of the three write enables, with a distinct address and data on each worker. It also injects done strobes from the wrong workers and stray `go` pulses. The bench repeats the full sequence with done latencies from zero cycles up to several cycles, including a done strobe in the same cycle as the start pulse. It also runs one reset that cuts a transform short.

// File: rtl/fft_seq_pkg.sv
package fft_seq_pkg;

    localparam int NUM_UNITS = 3;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_LOAD = 3'd1,
        PH_BFLY = 3'd2,
        PH_OUT  = 3'd3,
        PH_FIN  = 3'd4
    } phase_t;

    // One-hot owner of the memory port per phase; bit 0 loader, 1 butterfly, 2 streamer
    function automatic logic [NUM_UNITS-1:0] owner_of(phase_t p);
        case (p)
            PH_LOAD: owner_of = 3'b001;
            PH_BFLY: owner_of = 3'b010;
            PH_OUT:  owner_of = 3'b100;
            default: owner_of = 3'b000;
        endcase
    endfunction

    function automatic phase_t phase_after(phase_t p);
        case (p)
            PH_LOAD: phase_after = PH_BFLY;
            PH_BFLY: phase_after = PH_OUT;
            PH_OUT:  phase_after = PH_FIN;
            default: phase_after = PH_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/fft_seq_fsm.sv
module fft_seq_fsm
    import fft_seq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 go,
    input  logic [NUM_UNITS-1:0] done,
    output phase_t               phase,
    output logic [NUM_UNITS-1:0] grant,
    output logic [NUM_UNITS-1:0] starts,
    output logic                 busy,
    output logic                 complete
);

    phase_t phase_q, phase_d;
    logic   fresh_q;
    logic   owner_done;

    assign grant      = owner_of(phase_q);
    assign owner_done = |(grant & done);

    always_comb begin
        phase_d = phase_q;
        case (phase_q)
            PH_IDLE:                   if (go) phase_d = PH_LOAD;
            PH_LOAD, PH_BFLY, PH_OUT:  if (owner_done) phase_d = phase_after(phase_q);
            PH_FIN:                    phase_d = PH_IDLE;
            default:                   phase_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            fresh_q <= 1'b0;
        end else begin
            phase_q <= phase_d;
            fresh_q <= (phase_d != phase_q) && (owner_of(phase_d) != '0);
        end
    end

    assign phase    = phase_q;
    assign starts   = fresh_q ? grant : '0;
    assign busy     = (grant != '0);
    assign complete = (phase_q == PH_FIN);

endmodule

// File: rtl/fft_seq_port_mux.sv
module fft_seq_port_mux #(
    parameter int NU = 3,
    parameter int AW = 6,
    parameter int DW = 16
) (
    input  logic [NU-1:0]         grant,
    input  logic [NU-1:0][AW-1:0] req_addr,
    input  logic [NU-1:0][DW-1:0] req_wre,
    input  logic [NU-1:0][DW-1:0] req_wim,
    input  logic [NU-1:0]         req_we,
    output logic [AW-1:0]         mem_addr,
    output logic [DW-1:0]         mem_wre,
    output logic [DW-1:0]         mem_wim,
    output logic                  mem_we
);

    logic [NU-1:0][AW-1:0] m_addr;
    logic [NU-1:0][DW-1:0] m_wre;
    logic [NU-1:0][DW-1:0] m_wim;
    logic [NU-1:0]         m_we;

    for (genvar g = 0; g < NU; g++) begin : g_mask
        assign m_addr[g] = grant[g] ? req_addr[g] : '0;
        assign m_wre[g]  = grant[g] ? req_wre[g]  : '0;
        assign m_wim[g]  = grant[g] ? req_wim[g]  : '0;
        assign m_we[g]   = grant[g] & req_we[g];
    end

    always_comb begin
        mem_addr = '0;
        mem_wre  = '0;
        mem_wim  = '0;
        for (int i = 0; i < NU; i++) begin
            mem_addr = mem_addr | m_addr[i];
            mem_wre  = mem_wre  | m_wre[i];
            mem_wim  = mem_wim  | m_wim[i];
        end
        mem_we = |m_we;
    end

endmodule

// File: rtl/fft_phase_sequencer.sv
module fft_phase_sequencer
    import fft_seq_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    output logic              ld_start,
    input  logic              ld_done,
    output logic              bf_start,
    input  logic              bf_done,
    output logic              os_start,
    input  logic              os_done,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [DATA_W-1:0] ld_wr_re,
    input  logic [DATA_W-1:0] ld_wr_im,
    input  logic              ld_we,
    input  logic [ADDR_W-1:0] bf_addr,
    input  logic [DATA_W-1:0] bf_wr_re,
    input  logic [DATA_W-1:0] bf_wr_im,
    input  logic              bf_we,
    input  logic [ADDR_W-1:0] os_addr,
    input  logic [DATA_W-1:0] os_wr_re,
    input  logic [DATA_W-1:0] os_wr_im,
    input  logic              os_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wr_re,
    output logic [DATA_W-1:0] mem_wr_im,
    output logic              mem_we,
    input  logic [DATA_W-1:0] mem_rd_re,
    input  logic [DATA_W-1:0] mem_rd_im,
    output logic [DATA_W-1:0] rd_re,
    output logic [DATA_W-1:0] rd_im,
    output logic              busy,
    output logic              complete
);

    phase_t               phase_q;
    logic [NUM_UNITS-1:0] grant;
    logic [NUM_UNITS-1:0] starts;

    fft_seq_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .go       (go),
        .done     ({os_done, bf_done, ld_done}),
        .phase    (phase_q),
        .grant    (grant),
        .starts   (starts),
        .busy     (busy),
        .complete (complete)
    );

    assign ld_start = starts[0];
    assign bf_start = starts[1];
    assign os_start = starts[2];

    fft_seq_port_mux #(
        .NU (NUM_UNITS),
        .AW (ADDR_W),
        .DW (DATA_W)
    ) u_mux (
        .grant    (grant),
        .req_addr ({os_addr,  bf_addr,  ld_addr}),
        .req_wre  ({os_wr_re, bf_wr_re, ld_wr_re}),
        .req_wim  ({os_wr_im, bf_wr_im, ld_wr_im}),
        .req_we   ({os_we,    bf_we,    ld_we}),
        .mem_addr (mem_addr),
        .mem_wre  (mem_wr_re),
        .mem_wim  (mem_wr_im),
        .mem_we   (mem_we)
    );

    // Read data is broadcast to every worker regardless of ownership
    assign rd_re = mem_rd_re;
    assign rd_im = mem_rd_im;

endmodule

// File: rtl/fft_seq_checker.sv
module fft_seq_checker
    import fft_seq_pkg::*;
#(
    parameter int AW = 6
) (
    input logic          clk,
    input logic          rst,
    input logic          go,
    input phase_t        phase,
    input logic          ld_start,
    input logic          bf_start,
    input logic          os_start,
    input logic          ld_done,
    input logic          bf_done,
    input logic          os_done,
    input logic [AW-1:0] mem_addr,
    input logic [AW-1:0] ld_addr,
    input logic [AW-1:0] bf_addr,
    input logic [AW-1:0] os_addr,
    input logic          mem_we,
    input logic          ld_we,
    input logic          bf_we,
    input logic          os_we,
    input logic          busy,
    input logic          complete
);

    p_single_start_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ld_start, bf_start, os_start}));

    p_go_launch_r2: assert property (@(posedge clk) disable iff (rst)
        (!busy && !complete && go) |=> (ld_start && busy));

    p_load_then_bfly_r3: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_LOAD && ld_done) |=> bf_start);

    p_bfly_then_out_r3: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_BFLY && bf_done) |=> os_start);

    p_stray_done_r4: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_LOAD && !ld_done) |=> (phase == PH_LOAD && !bf_start));

    p_route_load_r5: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_LOAD) |-> (mem_addr == ld_addr && mem_we == ld_we));

    p_route_bfly_r5: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_BFLY) |-> (mem_addr == bf_addr && mem_we == bf_we));

    p_route_out_r5: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_OUT) |-> (mem_addr == os_addr && mem_we == os_we));

    p_idle_no_write_r6: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_we);

    p_complete_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        complete |=> (!complete && !busy));

    p_out_finish_r8: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_OUT && os_done) |=> complete);

    p_go_ignored_r9: assert property (@(posedge clk) disable iff (rst)
        (busy || complete) |=> !ld_start);

endmodule

bind fft_phase_sequencer fft_seq_checker #(.AW(ADDR_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .go       (go),
    .phase    (phase_q),
    .ld_start (ld_start),
    .bf_start (bf_start),
    .os_start (os_start),
    .ld_done  (ld_done),
    .bf_done  (bf_done),
    .os_done  (os_done),
    .mem_addr (mem_addr),
    .ld_addr  (ld_addr),
    .bf_addr  (bf_addr),
    .os_addr  (os_addr),
    .mem_we   (mem_we),
    .ld_we    (ld_we),
    .bf_we    (bf_we),
    .os_we    (os_we),
    .busy     (busy),
    .complete (complete)
);

// File: tb/fft_phase_sequencer_bench.sv
module fft_phase_sequencer_bench;

    localparam int AW = 6;
    localparam int DW = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic go = 1'b0;
    logic ld_done = 1'b0, bf_done = 1'b0, os_done = 1'b0;
    logic ld_start, bf_start, os_start;
    logic [AW-1:0] ld_addr = '0, bf_addr = '0, os_addr = '0;
    logic [DW-1:0] ld_wr_re = '0, ld_wr_im = '0;
    logic [DW-1:0] bf_wr_re = '0, bf_wr_im = '0;
    logic [DW-1:0] os_wr_re = '0, os_wr_im = '0;
    logic ld_we = 1'b0, bf_we = 1'b0, os_we = 1'b0;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wr_re, mem_wr_im, rd_re, rd_im;
    logic [DW-1:0] mem_rd_re = '0, mem_rd_im = '0;
    logic mem_we, busy, complete;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    fft_phase_sequencer #(.ADDR_W(AW), .DATA_W(DW)) u_fft_phase_sequencer (
        .clk(clk), .rst(rst), .go(go),
        .ld_start(ld_start), .ld_done(ld_done),
        .bf_start(bf_start), .bf_done(bf_done),
        .os_start(os_start), .os_done(os_done),
        .ld_addr(ld_addr), .ld_wr_re(ld_wr_re), .ld_wr_im(ld_wr_im), .ld_we(ld_we),
        .bf_addr(bf_addr), .bf_wr_re(bf_wr_re), .bf_wr_im(bf_wr_im), .bf_we(bf_we),
        .os_addr(os_addr), .os_wr_re(os_wr_re), .os_wr_im(os_wr_im), .os_we(os_we),
        .mem_addr(mem_addr), .mem_wr_re(mem_wr_re), .mem_wr_im(mem_wr_im), .mem_we(mem_we),
        .mem_rd_re(mem_rd_re), .mem_rd_im(mem_rd_im),
        .rd_re(rd_re), .rd_im(rd_im), .busy(busy), .complete(complete)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
        #1;
    endtask

    function automatic logic [AW-1:0] a_of(int k, int s);
        return AW'(k * 13 + s * 5 + 1);
    endfunction
    function automatic logic [DW-1:0] re_of(int k, int s);
        return DW'(k * 1000 + s * 7 + 3);
    endfunction
    function automatic logic [DW-1:0] im_of(int k, int s);
        return DW'(k * 77 + s * 11 + 9);
    endfunction

    // ph: 0 loader, 1 butterfly, 2 streamer, 3 none active
    task automatic sweep_routes(input int ph);
        for (int s = 0; s < 8; s++) begin
            ld_addr = a_of(0, s); ld_wr_re = re_of(0, s); ld_wr_im = im_of(0, s); ld_we = s[0];
            bf_addr = a_of(1, s); bf_wr_re = re_of(1, s); bf_wr_im = im_of(1, s); bf_we = s[1];
            os_addr = a_of(2, s); os_wr_re = re_of(2, s); os_wr_im = im_of(2, s); os_we = s[2];
            mem_rd_re = DW'(s * 321 + ph); mem_rd_im = DW'(s * 123 + 7);
            #1;
            if (ph < 3) begin
                chk(mem_addr == a_of(ph, s), "R5 addr", mem_addr, a_of(ph, s));
                chk(mem_wr_re == re_of(ph, s) && mem_wr_im == im_of(ph, s), "R5 data",
                    {mem_wr_re, mem_wr_im}, {re_of(ph, s), im_of(ph, s)});
                chk(mem_we == s[ph], "R6 we masking", mem_we, s[ph]);
            end else begin
                chk(mem_we == 1'b0 && mem_addr == '0 && mem_wr_re == '0 && mem_wr_im == '0,
                    "R6 idle quiet", {mem_we, mem_addr}, 0);
            end
            chk(rd_re == DW'(s * 321 + ph) && rd_im == DW'(s * 123 + 7), "R7 broadcast",
                {rd_re, rd_im}, {DW'(s * 321 + ph), DW'(s * 123 + 7)});
            cyc();
        end
        ld_we = 1'b0; bf_we = 1'b0; os_we = 1'b0;
    endtask

    function automatic logic [2:0] starts_vec();
        return {os_start, bf_start, ld_start};
    endfunction

    // One full transform: dly idle cycles per phase before done, with stray strobes when noisy
    task automatic run_xform(input int dly, input bit noisy, input bit routes);
        chk(!busy && !complete, "R1 idle before go", {busy, complete}, 0);
        if (routes) sweep_routes(3);
        go = 1'b1;
        cyc();
        go = 1'b0;
        chk(starts_vec() == 3'b001 && busy, "R2 loader start", {starts_vec(), busy}, 4'b0011);
        for (int ph = 0; ph < 3; ph++) begin
            if (routes) sweep_routes(ph);
            for (int i = 0; i < dly; i++) begin
                if (noisy) begin
                    ld_done = (ph != 0); bf_done = (ph != 1); os_done = (ph != 2);
                    go = 1'b1;
                end
                cyc();
                chk(starts_vec() == 3'b000 && busy && !complete, "R4 R9 stray strobes ignored",
                    {starts_vec(), busy, complete}, 5'b00010);
            end
            ld_done = (ph == 0); bf_done = (ph == 1); os_done = (ph == 2);
            go = noisy;
            cyc();
            ld_done = 1'b0; bf_done = 1'b0; os_done = 1'b0; go = 1'b0;
            if (ph < 2) begin
                chk(starts_vec() == (3'b010 << ph), "R3 next phase start", starts_vec(), 3'b010 << ph);
            end else begin
                chk(complete && !busy && starts_vec() == 3'b000, "R8 complete flag",
                    {complete, busy}, 2'b10);
            end
        end
        go = noisy;
        cyc();
        go = 1'b0;
        chk(!complete && !busy && starts_vec() == 3'b000, "R8 R9 back to idle",
            {complete, busy, starts_vec()}, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        go = 1'b1;
        ld_we = 1'b1; bf_we = 1'b1; os_we = 1'b1;
        cyc();
        chk(!busy && !complete && !mem_we && starts_vec() == 3'b000, "R1 reset state",
            {busy, complete, mem_we, starts_vec()}, 0);
        cyc();
        rst = 1'b0;
        go = 1'b0;
        ld_we = 1'b0; bf_we = 1'b0; os_we = 1'b0;
        cyc();
        chk(!busy && !complete && starts_vec() == 3'b000, "R1 after release",
            {busy, complete, starts_vec()}, 0);

        run_xform(0, 1'b0, 1'b1);
        run_xform(1, 1'b1, 1'b0);
        run_xform(3, 1'b1, 1'b1);
        for (int d = 0; d < 6; d++) run_xform(d, d[0], 1'b0);

        // R10: abort in butterfly phase
        go = 1'b1;
        cyc();
        go = 1'b0;
        ld_done = 1'b1;
        cyc();
        ld_done = 1'b0;
        chk(bf_start, "R10 reached butterfly", bf_start, 1);
        rst = 1'b1;
        cyc();
        rst = 1'b0;
        cyc();
        chk(!busy && !complete && starts_vec() == 3'b000, "R10 abort to idle",
            {busy, complete, starts_vec()}, 0);
        bf_done = 1'b1;
        cyc();
        bf_done = 1'b0;
        chk(starts_vec() == 3'b000 && !busy, "R10 R4 done after abort ignored",
            {starts_vec(), busy}, 0);
        run_xform(2, 1'b1, 1'b1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule